// File: doc/BRIEF.md
# Inverted-Feedback Block-Step Pattern Generator

This block produces 32-bit pseudo-random words for memory test traffic. Its state is a shift register that moves right by one position per step and feeds a new bit into the top position. The new bit is the inverse of bit 0, XORed with bits 1, 2 and 22. Because of this inversion, the all-zero state is an ordinary state in the sequence. The all-ones state maps onto itself and is the one stuck state.

A single advance request applies a full block of 32 steps within one clock. Every request therefore replaces all 32 bits of the output word. A synchronous seed load sets the starting point and takes priority over an advance in the same cycle. The block drives a flag whenever it sits in the stuck state.

Top module: `xnor_lfsr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes 0. After that edge, `word_out` reads 0 and `locked` reads 0.
- R2: When `seed_load` is high at a rising edge, `word_out` equals that cycle's `seed_value` after the edge.
- R3: When `advance` is high and `seed_load` is low at a rising edge, the state after the edge results from 32 single steps. Each step computes a new bit as NOT(s[0]) XOR s[1] XOR s[2] XOR s[22], shifts the state right by one, and places the new bit in s[31].
- R4: When neither `seed_load` nor `advance` is high at a rising edge, `word_out` keeps its value.
- R5: An advance taken from the all-zero state yields a nonzero word.
- R6: `locked` is 1 exactly when every bit of `word_out` is 1.
- R7: From the all-ones state, an advance leaves the state at all ones, and `locked` stays high.
- R8: When `seed_load` and `advance` are both high at an edge, the seed is loaded and no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Load `seed_value` into the state |
| seed_value | input | 32 | Starting word to load |
| advance | input | 1 | Apply one 32-step block |
| word_out | output | 32 | Current pattern word |
| locked | output | 1 | High while the state is all ones |

## Verification
On every cycle, the assertions check four things: that a seed lands on the next edge, that an idle cycle holds the word, that an advance from zero gives a nonzero result, and that the all-ones state stays locked under an advance. Only the bench's scenarios can confirm the exact bit pattern an advance produces. The bench compares it against an independent step-by-step model across chains of advances, seed loads, load-with-advance collisions and the locked state. It also checks the reset value and the lock flag on every compared cycle.

// File: rtl/lfsr_pkg.sv
// Shared selection type for the pattern generator's next-state choice.
// Assumes nothing beyond the three update sources the top module uses.
package lfsr_pkg;
    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_STEP = 2'd2
    } next_sel_e;

    // Priority: a load beats an advance, and an advance beats a hold.
    function automatic next_sel_e pick_source(input logic load, input logic adv);
        if (load)     return SEL_LOAD;
        else if (adv) return SEL_STEP;
        else          return SEL_HOLD;
    endfunction
endpackage

// File: rtl/lfsr_shift_stage.sv
// One combinational step: right shift by one with an inverted-XOR bit at the top.
// Assumes every tap index is below WIDTH.
module lfsr_shift_stage #(
    parameter int WIDTH = 32,
    parameter int TAP_A = 0,
    parameter int TAP_B = 1,
    parameter int TAP_C = 2,
    parameter int TAP_D = 22
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    logic fb;

    // Feedback bit: the first tap is inverted, and the rest are XORed in.
    always_comb fb = ~cur[TAP_A] ^ cur[TAP_B] ^ cur[TAP_C] ^ cur[TAP_D];

    // Shift right and insert the feedback bit at the top.
    always_comb nxt = {fb, cur[WIDTH-1:1]};
endmodule

// File: rtl/lfsr_step_chain.sv
// Unrolled chain of STEPS single-bit stages that settles within one clock.
// Assumes STEPS >= 1; logic depth grows linearly with STEPS.
module lfsr_step_chain #(
    parameter int WIDTH = 32,
    parameter int STEPS = 32,
    parameter int TAP_A = 0,
    parameter int TAP_B = 1,
    parameter int TAP_C = 2,
    parameter int TAP_D = 22
) (
    input  logic [WIDTH-1:0] start,
    output logic [WIDTH-1:0] finish
);
    logic [WIDTH-1:0] link [0:STEPS];

    // Feed the chain input.
    always_comb link[0] = start;

    genvar g;
    generate
        for (g = 0; g < STEPS; g++) begin : g_stage
            lfsr_shift_stage #(
                .WIDTH(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B),
                .TAP_C(TAP_C), .TAP_D(TAP_D)
            ) u_stage (
                .cur(link[g]),
                .nxt(link[g+1])
            );
        end
    endgenerate

    // Output of the last stage.
    always_comb finish = link[STEPS];
endmodule

// File: rtl/lfsr_lock_detect.sv
// Flags the stuck all-ones state. Assumes the inverted feedback, so that all
// ones is the only fixed point.
module lfsr_lock_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] state,
    output logic             stuck
);
    // AND-reduce the state bits.
    always_comb stuck = &state;
endmodule

// File: rtl/xnor_lfsr_gen.sv
// Top of the pattern generator. It holds the state, picks load, advance or
// hold, and flags the locked state. Assumes a synchronous active-low reset
// and that a load in the same cycle as an advance wins.
module xnor_lfsr_gen #(
    parameter int WIDTH         = 32,
    parameter int STEPS_PER_ADV = 32,
    parameter int TAP_A         = 0,
    parameter int TAP_B         = 1,
    parameter int TAP_C         = 2,
    parameter int TAP_D         = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_value,
    input  logic             advance,
    output logic [WIDTH-1:0] word_out,
    output logic             locked
);
    import lfsr_pkg::*;

    localparam logic [WIDTH-1:0] RESET_WORD = '0;
    localparam logic [WIDTH-1:0] ALL_ONES   = '1;

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] stepped;
    next_sel_e        sel;

    lfsr_step_chain #(
        .WIDTH(WIDTH), .STEPS(STEPS_PER_ADV),
        .TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C), .TAP_D(TAP_D)
    ) u_chain (
        .start (state_q),
        .finish(stepped)
    );

    lfsr_lock_detect #(.WIDTH(WIDTH)) u_lock (
        .state(state_q),
        .stuck(locked)
    );

    // Choose the update source, with load taking priority.
    always_comb sel = pick_source(seed_load, advance);

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_WORD;
        end else begin
            case (sel)
                SEL_LOAD: state_q <= seed_value;
                SEL_STEP: state_q <= stepped;
                default:  state_q <= state_q;
            endcase
        end
    end

    // Present the state.
    always_comb word_out = state_q;

    // R2 and R8: a load lands on the next edge, even when advance is also high.
    p_seed_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> word_out == $past(seed_value));

    // R4: an idle cycle keeps the word.
    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !advance) |=> $stable(word_out));

    // R5: the all-zero state is not stuck.
    p_zero_escapes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && advance && word_out == RESET_WORD) |=> word_out != RESET_WORD);

    // R7: the all-ones state stays locked under an advance.
    p_lock_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && advance && word_out == ALL_ONES) |=> (locked && word_out == ALL_ONES));
endmodule

// File: tb/tb_xnor_lfsr_gen.sv
module tb_xnor_lfsr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [31:0] seed_value = '0;
    logic        advance = 1'b0;
    logic [31:0] word_out;
    logic        locked;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [31:0] model = '0;

    always #4 clk = ~clk;

    xnor_lfsr_gen dut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
        .advance(advance), .word_out(word_out), .locked(locked)
    );

    // Behavioural reference: 32 single steps, done with plain integer bit arithmetic.
    function automatic logic [31:0] ref_block(input logic [31:0] s);
        logic [31:0] v = s;
        for (int i = 0; i < 32; i++) begin
            int b;
            b = (1 - int'(v[0])) + int'(v[1]) + int'(v[2]) + int'(v[22]);
            v = (v >> 1) | (32'(b % 2) << 31);
        end
        return v;
    endfunction

    task automatic compare(input string req);
        n_cmp++;
        if (word_out !== model) begin
            n_bad++;
            $display("FAIL %s word: actual %h expected %h", req, word_out, model);
        end
        n_cmp++;
        if (locked !== (model == 32'hffff_ffff)) begin
            n_bad++;
            $display("FAIL R6 locked (%s): actual %b expected %b", req, locked,
                     model == 32'hffff_ffff);
        end
    endtask

    // Drive one cycle from a negedge, update the model, and compare at the next negedge.
    task automatic cycle(input logic rn, input logic ld, input logic [31:0] sd,
                         input logic adv, input string req);
        rst_n = rn; seed_load = ld; seed_value = sd; advance = adv;
        if (!rn)     model = '0;
        else if (ld) model = sd;
        else if (adv) model = ref_block(model);
        @(negedge clk);
        compare(req);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycle(1'b0, 1'b1, 32'h1234_5678, 1'b1, "R1");   // reset beats load
        cycle(1'b0, 1'b0, 32'h0, 1'b0, "R1");
        cycle(1'b1, 1'b0, 32'h0, 1'b1, "R5");           // advance from zero
        for (int k = 0; k < 6; k++) cycle(1'b1, 1'b0, 32'h0, 1'b1, "R3");
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 32'hdead_beef, 1'b0, "R4");
        cycle(1'b1, 1'b1, 32'hcafe_f00d, 1'b0, "R2");
        cycle(1'b1, 1'b0, 32'h0, 1'b1, "R3");
        cycle(1'b1, 1'b1, 32'h0000_0001, 1'b1, "R8");   // load beats advance
        cycle(1'b1, 1'b0, 32'h0, 1'b0, "R4");
        cycle(1'b1, 1'b0, 32'h0, 1'b1, "R3");
        cycle(1'b1, 1'b1, 32'hffff_ffff, 1'b0, "R6");
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 32'h0, 1'b1, "R7");
        cycle(1'b1, 1'b1, 32'hffff_fffe, 1'b0, "R6");   // one bit short of locked
        cycle(1'b1, 1'b0, 32'h0, 1'b1, "R3");
        cycle(1'b1, 1'b1, 32'h8000_0000, 1'b1, "R8");
        for (int k = 0; k < 200; k++) begin
            logic [31:0] r = $urandom;
            int pick = $urandom_range(0, 9);
            if (pick == 0)      cycle(1'b1, 1'b1, r, 1'b0, "R2");
            else if (pick == 1) cycle(1'b1, 1'b1, r, 1'b1, "R8");
            else if (pick < 4)  cycle(1'b1, 1'b0, r, 1'b0, "R4");
            else                cycle(1'b1, 1'b0, r, 1'b1, "R3");
        end
        cycle(1'b0, 1'b0, 32'h0, 1'b1, "R1");
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule